// File: doc/BRIEF.md
# Zero Run-Length Encoder with Byte Packer

This block turns a stream of fixed-width data words into a compact flag stream that records where the zeros are. Every word is tested for zero. A non-zero word adds one `1` bit to the stream. Consecutive zero words are counted and leave the stream as one symbol: a `0` bit followed by a fixed-width count field. The variable-length symbols are packed into bytes for a memory bus. Every non-zero word also leaves, unchanged and in arrival order, on a separate value port so that a downstream stage can compress the values.

Three handshakes connect the block: one for the input words, one for the packed output bytes and one for the forwarded non-zero values. A flush request ends a stream. The flush writes out any zero run still being counted, pads the last partial byte with zeros, and then reports completion.

A three-state machine controls the flow:
- `ST_STREAM` accepts words. It moves to `ST_PAD` when a flush is taken, which needs the packer to hold fewer than eight bits.
- `ST_PAD` drains every packed bit, padding the last byte. It moves to `ST_DONE` once the packer is empty.
- `ST_DONE` raises `flush_done` for one cycle and always returns to `ST_STREAM`.

Top module: `zero_run_packer`

## Requirements
- R1: A non-zero input word adds exactly one `1` bit to the stream. Stream bits fill each output byte from bit 0 upward, so the k-th stream bit appears at bit k mod 8 of output byte k/8.
- R2: A run of L zero words (1 ≤ L ≤ 16) is emitted as one `0` bit followed by the 4-bit field L−1, least significant field bit first. The symbol is emitted when the next non-zero word arrives, and it comes before that word's `1` bit.
- R3: On the 16th consecutive zero, the symbol with field value 15 is emitted at once and counting restarts. Seventeen zeros therefore code as a 16-run symbol followed by a 1-run symbol.
- R4: A flush emits any pending run symbol and then any partial byte, with the unused upper bits set to 0. `flush_done` is high for one cycle once no packed bit remains. The flush request must be held high until it sees `flush_done`.
- R5: While `flush_req` is high, or while a flush is still draining, `in_ready` is low and no word is taken.
- R6: Every non-zero word appears once on `nz_data`, unchanged and in input order. Zero words never appear there, and `nz_valid` and `nz_data` hold steady while `nz_ready` is low.
- R7: `out_data` and `out_valid` hold steady while `out_ready` is low. No byte is lost or repeated under back-pressure.
- R8: After reset, and after a reset applied in the middle of a stream, `out_valid`, `nz_valid` and `flush_done` are low, `in_ready` is high, and no earlier bit or count carries into the next stream.
- R9: A flush with no pending run and no packed bits produces no output byte and still completes with `flush_done`.
- R10: While a forwarded value waits and `nz_ready` is low, `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block takes the offered word this cycle |
| in_data | input | DATA_W | Input word |
| flush_req | input | 1 | End-of-stream request, held until `flush_done` |
| flush_done | output | 1 | Flush complete, one cycle |
| out_valid | output | 1 | Packed byte available |
| out_ready | input | 1 | Consumer takes the packed byte |
| out_data | output | OUT_W | Packed flag/run byte |
| nz_valid | output | 1 | Forwarded non-zero value available |
| nz_ready | input | 1 | Consumer takes the forwarded value |
| nz_data | output | DATA_W | Forwarded non-zero value |

## Verification
The assertions check the following on every cycle:
- the output byte and the forwarded value stay stable under back-pressure;
- a forwarded value is never zero;
- input is refused while a flush is requested or a forwarded value is stalled;
- `flush_done` occurs only with an empty packer;
- the 16th consecutive zero always pushes a symbol;
- the packer accepts symbols only below one byte of fill.

The exact bit layout of the output bytes can be shown only by the bench's scenarios:
- the order of run fields and flag bits;
- where a full-length run is split;
- zero padding after a flush;
- the absence of any byte after an empty flush.

The bench compares each byte with a bit-level model under several back-pressure patterns.

// File: rtl/zrp_pkg.sv
package zrp_pkg;

    // Control states of the packer front end
    typedef enum logic [1:0] {
        ST_STREAM = 2'd0,  // accepting words
        ST_PAD    = 2'd1,  // flush taken, draining bits incl. padded byte
        ST_DONE   = 2'd2   // flush finished, one-cycle completion
    } zrp_state_e;

endpackage

// File: rtl/zrp_run_coder.sv
module zrp_run_coder #(
    parameter int DATA_W = 8,
    parameter int RUN_W  = 4,
    localparam int SYM_W = RUN_W + 2,
    localparam int LEN_W = $clog2(SYM_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_take,
    input  logic [DATA_W-1:0] word_data,
    input  logic              flush_take,
    output logic              sym_push,
    output logic [SYM_W-1:0]  sym_bits,
    output logic [LEN_W-1:0]  sym_len,
    output logic [RUN_W-1:0]  run_pending
);

    localparam int MAX_RUN = 1 << RUN_W;
    localparam logic [RUN_W-1:0] LAST_CNT = RUN_W'(MAX_RUN - 1);

    logic              is_zero;
    logic [RUN_W-1:0]  run_q;
    logic [RUN_W-1:0]  run_d;
    logic [RUN_W-1:0]  run_field;

    // NOR over the whole word
    assign is_zero     = ~|word_data;
    assign run_field   = run_q - RUN_W'(1);
    assign run_pending = run_q;

    always_comb begin
        sym_push = 1'b0;
        sym_bits = '0;
        sym_len  = '0;
        run_d    = run_q;
        if (word_take) begin
            if (is_zero) begin
                if (run_q == LAST_CNT) begin
                    // longest run reached: emit field all-ones, restart
                    sym_push = 1'b1;
                    sym_bits = {1'b0, {RUN_W{1'b1}}, 1'b0};
                    sym_len  = LEN_W'(RUN_W + 1);
                    run_d    = '0;
                end else begin
                    run_d = run_q + RUN_W'(1);
                end
            end else begin
                sym_push = 1'b1;
                run_d    = '0;
                if (run_q != '0) begin
                    // pending run first (low bits), then the flag bit
                    sym_bits = {1'b1, run_field, 1'b0};
                    sym_len  = LEN_W'(RUN_W + 2);
                end else begin
                    sym_bits = SYM_W'(1);
                    sym_len  = LEN_W'(1);
                end
            end
        end else if (flush_take && run_q != '0) begin
            sym_push = 1'b1;
            sym_bits = {1'b0, run_field, 1'b0};
            sym_len  = LEN_W'(RUN_W + 1);
            run_d    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

endmodule

// File: rtl/zrp_bit_packer.sv
module zrp_bit_packer #(
    parameter int OUT_W = 8,
    parameter int SYM_W = 6,
    parameter int LEN_W = 3,
    localparam int ACC_W  = OUT_W - 1 + SYM_W,
    localparam int FILL_W = $clog2(ACC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SYM_W-1:0]  bits,
    input  logic [LEN_W-1:0]  len,
    input  logic              pad_en,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data,
    output logic [FILL_W-1:0] fill
);

    logic [ACC_W-1:0]  acc_q, acc_d;
    logic [FILL_W-1:0] fill_q, fill_d;
    logic              full_word;
    logic              part_word;
    logic              drain;

    assign full_word = fill_q >= FILL_W'(OUT_W);
    assign part_word = pad_en && (fill_q != '0) && !full_word;
    assign out_valid = full_word || part_word;
    // bits above the fill level are always zero, giving the padding
    assign out_data  = acc_q[OUT_W-1:0];
    assign drain     = out_valid && out_ready;
    assign fill      = fill_q;

    always_comb begin
        acc_d  = acc_q;
        fill_d = fill_q;
        if (drain) begin
            acc_d  = acc_q >> OUT_W;
            fill_d = full_word ? fill_q - FILL_W'(OUT_W) : '0;
        end else if (push) begin
            acc_d  = acc_q | (ACC_W'(bits) << fill_q);
            fill_d = fill_q + FILL_W'(len);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            fill_q <= '0;
        end else begin
            acc_q  <= acc_d;
            fill_q <= fill_d;
        end
    end

endmodule

// File: rtl/zrp_nz_slot.sv
module zrp_nz_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              nz_ready,
    output logic              nz_valid,
    output logic [DATA_W-1:0] nz_data,
    output logic              room
);

    logic              valid_q;
    logic [DATA_W-1:0] data_q;

    assign nz_valid = valid_q;
    assign nz_data  = data_q;
    assign room     = !valid_q || nz_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            data_q  <= load_data;
        end else if (nz_ready) begin
            valid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/zero_run_packer.sv
module zero_run_packer
    import zrp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RUN_W  = 4,
    parameter int OUT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              flush_req,
    output logic              flush_done,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_W-1:0]  out_data,
    output logic              nz_valid,
    input  logic              nz_ready,
    output logic [DATA_W-1:0] nz_data
);

    localparam int SYM_W  = RUN_W + 2;
    localparam int LEN_W  = $clog2(SYM_W + 1);
    localparam int ACC_W  = OUT_W - 1 + SYM_W;
    localparam int FILL_W = $clog2(ACC_W + 1);

    zrp_state_e        state_q, state_d;
    logic              take_word;
    logic              take_flush;
    logic              pad_en;
    logic              room_ok;
    logic              nz_room;
    logic              sym_push;
    logic [SYM_W-1:0]  sym_bits;
    logic [LEN_W-1:0]  sym_len;
    logic [RUN_W-1:0]  run_pending;
    logic [FILL_W-1:0] fill;

    assign room_ok = fill < FILL_W'(OUT_W);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STREAM;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STREAM: if (flush_req && room_ok) state_d = ST_PAD;
            ST_PAD:    if (fill == '0)           state_d = ST_DONE;
            ST_DONE:                             state_d = ST_STREAM;
            default:                             state_d = ST_STREAM;
        endcase
    end

    // outputs of the control
    always_comb begin
        in_ready   = 1'b0;
        take_flush = 1'b0;
        pad_en     = 1'b0;
        flush_done = 1'b0;
        unique case (state_q)
            ST_STREAM: begin
                in_ready   = room_ok && nz_room && !flush_req;
                take_flush = flush_req && room_ok;
            end
            ST_PAD:  pad_en     = 1'b1;
            ST_DONE: flush_done = 1'b1;
            default: ;
        endcase
    end

    assign take_word = in_valid && in_ready;

    zrp_run_coder #(
        .DATA_W (DATA_W),
        .RUN_W  (RUN_W)
    ) coder_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_take   (take_word),
        .word_data   (in_data),
        .flush_take  (take_flush),
        .sym_push    (sym_push),
        .sym_bits    (sym_bits),
        .sym_len     (sym_len),
        .run_pending (run_pending)
    );

    zrp_bit_packer #(
        .OUT_W (OUT_W),
        .SYM_W (SYM_W),
        .LEN_W (LEN_W)
    ) packer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (sym_push),
        .bits      (sym_bits),
        .len       (sym_len),
        .pad_en    (pad_en),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .fill      (fill)
    );

    zrp_nz_slot #(
        .DATA_W (DATA_W)
    ) slot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take_word && (in_data != '0)),
        .load_data (in_data),
        .nz_ready  (nz_ready),
        .nz_valid  (nz_valid),
        .nz_data   (nz_data),
        .room      (nz_room)
    );

endmodule

// File: rtl/zrp_checker.sv
module zrp_checker #(
    parameter int DATA_W = 8,
    parameter int RUN_W  = 4,
    parameter int OUT_W  = 8,
    parameter int FILL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              flush_req,
    input logic              flush_done,
    input logic              out_valid,
    input logic              out_ready,
    input logic [OUT_W-1:0]  out_data,
    input logic              nz_valid,
    input logic              nz_ready,
    input logic [DATA_W-1:0] nz_data,
    input logic [FILL_W-1:0] fill,
    input logic              push,
    input logic [RUN_W-1:0]  run_pending
);

    localparam logic [RUN_W-1:0] LAST_CNT = RUN_W'((1 << RUN_W) - 1);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R6
    nz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nz_valid && !nz_ready |=> nz_valid && $stable(nz_data));

    // R6
    nz_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nz_valid |-> nz_data != '0);

    // R5
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !in_ready);

    // R4
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> !out_valid && fill == '0);

    // R3
    run_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_data == '0 && run_pending == LAST_CNT |-> push);

    // R2
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> fill < FILL_W'(OUT_W));

    // R10
    nz_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !nz_valid || nz_ready);

    // R8
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid && !nz_valid && !flush_done);

endmodule

bind zero_run_packer zrp_checker #(
    .DATA_W (DATA_W),
    .RUN_W  (RUN_W),
    .OUT_W  (OUT_W),
    .FILL_W (FILL_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .flush_req   (flush_req),
    .flush_done  (flush_done),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .nz_valid    (nz_valid),
    .nz_ready    (nz_ready),
    .nz_data     (nz_data),
    .fill        (fill),
    .push        (sym_push),
    .run_pending (run_pending)
);

// File: tb/zero_run_packer_tb.sv
`timescale 1ns/1ps
module zero_run_packer_tb_top;

    localparam int DW   = 8;
    localparam int RW   = 4;
    localparam int OW   = 8;
    localparam int MAXR = 1 << RW;
    localparam int WD   = 100000;

    // table entry: [9:8] op (0 word, 1 zero run of arg, 2 flush, 3 ready mode), [7:0] arg
    localparam int NT = 24;
    localparam logic [9:0] TBL [NT] = '{
        {2'd3, 8'd0}, {2'd0, 8'h11}, {2'd1, 8'd3},  {2'd0, 8'h22},
        {2'd1, 8'd16},{2'd0, 8'h80}, {2'd2, 8'd0},  {2'd3, 8'd1},
        {2'd1, 8'd17},{2'd0, 8'h01}, {2'd1, 8'd1},  {2'd0, 8'hff},
        {2'd0, 8'h12},{2'd0, 8'h34}, {2'd1, 8'd40}, {2'd2, 8'd0},
        {2'd3, 8'd2}, {2'd0, 8'h01}, {2'd1, 8'd5},  {2'd2, 8'd0},
        {2'd2, 8'd0}, {2'd1, 8'd16}, {2'd2, 8'd0},  {2'd3, 8'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          flush_req = 1'b0;
    logic          flush_done;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [OW-1:0] out_data;
    logic          nz_valid;
    logic          nz_ready = 1'b1;
    logic [DW-1:0] nz_data;

    zero_run_packer #(.DATA_W(DW), .RUN_W(RW), .OUT_W(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .flush_req(flush_req), .flush_done(flush_done),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .nz_valid(nz_valid), .nz_ready(nz_ready), .nz_data(nz_data)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int rmode = 0;
    int mrun = 0;
    int nbytes = 0;
    logic [7:0] last_byte = '0;
    logic [7:0] prev_byte = '0;
    logic [7:0] eb;
    bit mbits[$];
    logic [7:0] exp_bytes[$];
    logic [7:0] exp_nz[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    task automatic model_bit(input bit b);
        logic [7:0] v;
        mbits.push_back(b);
        if (mbits.size() == 8) begin
            for (int i = 0; i < 8; i++) v[i] = mbits.pop_front();
            exp_bytes.push_back(v);
        end
    endtask

    task automatic model_run();
        int f;
        f = mrun - 1;
        model_bit(1'b0);
        for (int i = 0; i < RW; i++) model_bit(bit'((f >> i) & 1));
        mrun = 0;
    endtask

    task automatic model_word(input logic [7:0] d);
        if (d == 0) begin
            mrun++;
            if (mrun == MAXR) model_run();
        end else begin
            if (mrun > 0) model_run();
            model_bit(1'b1);
            exp_nz.push_back(d);
        end
    endtask

    task automatic model_flush();
        if (mrun > 0) model_run();
        while (mbits.size() != 0) model_bit(1'b0);
    endtask

    // ---------------- drivers ----------------
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        case (rmode)
            1: begin out_ready = (cyc % 3) != 0; nz_ready = (cyc % 4) != 1; end
            2: begin out_ready = cyc[0];         nz_ready = (cyc % 5) == 0; end
            4: begin out_ready = 1'b1;           nz_ready = 1'b0;           end
            default: begin out_ready = 1'b1;     nz_ready = 1'b1;           end
        endcase
    end

    task automatic send(input logic [7:0] d);
        model_word(d);
        in_valid = 1'b1;
        in_data  = d;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send(8'h00);
    endtask

    task automatic do_flush();
        model_flush();
        flush_req = 1'b1;
        do @(negedge clk); while (!flush_done);
        chk(!out_valid, "R4", "out_valid at flush_done", out_valid, 0);
        @(posedge clk); #1;
        flush_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (exp_bytes.size() == 0 && exp_nz.size() == 0 && !out_valid && !nz_valid) break;
        end
        @(posedge clk); #1;
    endtask

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                nbytes++;
                prev_byte = last_byte;
                last_byte = out_data;
                if (exp_bytes.size() == 0) chk(1'b0, "R7", "unexpected byte", out_data, 0);
                else begin
                    eb = exp_bytes.pop_front();
                    chk(out_data == eb, "R7", "packed byte", out_data, eb);
                end
            end
            if (nz_valid && nz_ready) begin
                if (exp_nz.size() == 0) chk(1'b0, "R6", "unexpected value", nz_data, 0);
                else begin
                    eb = exp_nz.pop_front();
                    chk(nz_data == eb, "R6", "forwarded value", nz_data, eb);
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc == WD) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WD);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- sequence ----------------
    initial begin
        int n0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && !nz_valid && !flush_done, "R8", "idle in reset",
            {out_valid, nz_valid, flush_done}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready, "R8", "in_ready after reset", in_ready, 1);
        @(posedge clk); #1;

        // R1 R2: 05,00,00,07 -> bits 1,0,1000,1 padded -> 0x45
        n0 = nbytes;
        send(8'h05); send(8'h00); send(8'h00); send(8'h07);
        do_flush();
        wait_idle();
        chk(last_byte == 8'h45, "R1", "flag and run layout", last_byte, 8'h45);
        chk(nbytes - n0 == 1, "R2", "byte count for short run", nbytes - n0, 1);

        // table walk under several back-pressure patterns (R6 R7)
        for (int i = 0; i < NT; i++) begin
            case (TBL[i][9:8])
                2'd0: send(TBL[i][7:0]);
                2'd1: send_zeros(int'(TBL[i][7:0]));
                2'd2: do_flush();
                default: rmode = int'(TBL[i][7:0]);
            endcase
        end
        wait_idle();

        // R3: 17 zeros then 01 -> 0,1111 | 0,0000 | 1 -> 0x1E, 0x04
        rmode = 0;
        send_zeros(17); send(8'h01);
        do_flush();
        wait_idle();
        chk(prev_byte == 8'h1E, "R3", "split run first byte", prev_byte, 8'h1E);
        chk(last_byte == 8'h04, "R3", "split run second byte", last_byte, 8'h04);

        // R9: empty flush yields no byte
        n0 = nbytes;
        do_flush();
        wait_idle();
        chk(nbytes == n0, "R9", "bytes from empty flush", nbytes - n0, 0);

        // R5: offered word while flush requested is not taken
        in_valid = 1'b1; in_data = 8'h33;
        model_flush();
        flush_req = 1'b1;
        do begin
            @(negedge clk);
            chk(!in_ready, "R5", "in_ready during flush", in_ready, 0);
        end while (!flush_done);
        @(posedge clk); #1;
        flush_req = 1'b0; in_valid = 1'b0;
        wait_idle();

        // R10: stalled forwarded value blocks input
        rmode = 4;
        send(8'h09);
        model_word(8'h0A);
        in_valid = 1'b1; in_data = 8'h0A;
        repeat (3) begin
            @(negedge clk);
            chk(!in_ready, "R10", "in_ready with value stalled", in_ready, 0);
        end
        rmode = 0;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
        do_flush();
        wait_idle();

        // R8: reset in mid-stream discards pending state
        send(8'h01); send(8'h00); send(8'h00);
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b0;
        mbits.delete(); exp_bytes.delete(); exp_nz.delete(); mrun = 0;
        @(negedge clk);
        chk(!out_valid && !nz_valid && !flush_done, "R8", "idle after mid reset",
            {out_valid, nz_valid, flush_done}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        send(8'h22);
        do_flush();
        wait_idle();
        chk(last_byte == 8'h01, "R8", "fresh stream after reset", last_byte, 8'h01);

        chk(exp_bytes.size() == 0, "R7", "bytes left undelivered", exp_bytes.size(), 0);
        chk(exp_nz.size() == 0, "R6", "values left undelivered", exp_nz.size(), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule